// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from six sources and decides when the processor core should divert into a service routine. There are two external pins, two timer overflow strobes, an analog-converter completion strobe and a real-time clock tick. Each source has a sticky request flag and its own enable bit. A single master enable gates all of them. The external pins pass through a two-stage synchroniser. An edge detector then raises the flag, and a parameter selects whether it reacts to a falling edge, a rising edge or both. The four internal sources are single-cycle strobes that set their flags directly.

When the master enable is set, the return stack is not full and at least one enabled flag is pending, the controller drives a one-cycle call strobe. In that cycle it also presents the vector of the winning source. On the same clock edge it clears that source's flag and the master enable, so service routines do not nest. Requests that arrive while the master enable is off are only recorded. A return-from-interrupt strobe sets the master enable again, and any enabled flag still pending is then taken on the next cycle. A separate wake output reports any enabled pending flag, whatever the state of the master enable or the stack.

Top module: `vpic_top`

## Requirements
- R1: After reset all flags, all enables and the master enable are 0, and the call, wake and vector-related outputs show no request.
- R2: `call_o` is 1 in a cycle exactly when the master enable is 1, `stack_full_i` is 0 and at least one source has both its flag and its enable set; a flag whose enable is 0 never causes a call.
- R3: Flag and enable bit i belong to source i: 0 = external pin 0, 1 = external pin 1, 2 = timer 0, 3 = timer 1, 4 = converter done, 5 = clock tick. The lowest index wins, and `vec_o` is 0x04 + 4*i: 04, 08, 0C, 10, 14 and 18 hex.
- R4: On the clock edge that ends a cycle with `call_o` = 1, the flag of the serviced source and the master enable are cleared, and all other flags are kept.
- R5: While the master enable is 0, events set their flags and no call is made.
- R6: While `stack_full_i` is 1, no call is made. A pending request is taken in the first cycle in which `stack_full_i` is 0.
- R7: A one-cycle `reti_i` strobe sets the master enable on the next edge, and a pending enabled request is then called in the following cycle.
- R8: A flag stays set until it is serviced or cleared by its `flag_clr_i` bit. A new event in the same cycle as a clear or a service leaves the flag set.
- R9: `wake_o` is 1 exactly when some flag and its enable are both 1, independent of the master enable and of `stack_full_i`.
- R10: An external pin change is seen through two synchroniser flops: the flag is set on the third rising clock edge after the change. With the default configuration, pin 0 reacts only to falling edges and pin 1 reacts to both edges.
- R11: A `cfg_we_i` write loads all six enables and the master enable on the next edge. For the master enable, the write takes precedence over both a call and `reti_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 2 | Raw external request pins, idle high |
| evt_i | input | 4 | Internal event strobes: bit0 timer 0, bit1 timer 1, bit2 converter done, bit3 clock tick |
| cfg_we_i | input | 1 | Write strobe for the enables and the master enable |
| cfg_en_i | input | 6 | Per-source enable values to load |
| cfg_master_i | input | 1 | Master enable value to load |
| flag_clr_i | input | 6 | Software clear, one bit per source flag |
| reti_i | input | 1 | Return-from-interrupt strobe |
| stack_full_i | input | 1 | Return stack has no free entry |
| call_o | output | 1 | Take the interrupt call this cycle |
| vec_o | output | 8 | Call target of the winning source |
| wake_o | output | 1 | Some enabled flag is pending |
| flag_o | output | 6 | Current request flags |
| en_o | output | 6 | Current per-source enables |
| master_o | output | 1 | Current master enable |

## Verification
Several patterns exercise the priority selection. Two flags are raised together under a full stack and then released, which shows that the stack holds the call off and that the lower index wins. All four internal flags are raised at once and drained by repeated returns, which shows the full priority order and that one flag clears per entry. A disabled high-priority flag sits beside an enabled lower one, which shows that the enable masks both the choice and the wake output. The external pins are toggled in both directions, which separates falling-only detection from both-edge detection and pins down the three-edge latency. Same-cycle collisions (clear with event, write with return) show which side wins.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;
endpackage

// File: rtl/vpic_edge_det.sv
module vpic_edge_det
   import vpic_pkg::*;
#(
   parameter logic [1:0] MODE   = EDGE_FALL,
   parameter int         STAGES = 2,
   parameter logic       IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic hit_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("vpic_edge_det: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;
   logic              lvl;

   assign lvl = sync_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {STAGES{IDLE}};
         last_q <= IDLE;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         last_q <= lvl;
      end
   end

   if (MODE == EDGE_RISE) begin : g_rise
      assign hit_o = lvl & ~last_q;
   end else if (MODE == EDGE_FALL) begin : g_fall
      assign hit_o = ~lvl & last_q;
   end else if (MODE == EDGE_BOTH) begin : g_both
      assign hit_o = lvl ^ last_q;
   end else begin : g_off
      $error("vpic_edge_det: MODE selects no edge");
      assign hit_o = 1'b0;
   end
endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
   parameter int NSRC     = 6,
   parameter int VW       = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input  logic [NSRC-1:0] pend_i,
   output logic            any_o,
   output logic [NSRC-1:0] sel_o,
   output logic [VW-1:0]   vec_o
);
   localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

   logic [IW-1:0] idx;

   always_comb begin
      idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend_i[i]) idx = IW'(i);
      end
   end

   assign any_o = |pend_i;
   assign sel_o = any_o ? (NSRC'(1) << idx) : '0;
   assign vec_o = VW'(VEC_BASE + VEC_STEP * int'(idx));

   // R3: the chosen source is pending and no lower index is pending
   always_comb begin
      if (any_o) begin
         assert_lowest_wins_R3: assert (((pend_i & sel_o) != '0) &&
                                        ((pend_i & (sel_o - NSRC'(1))) == '0))
            else $error("priority pick is not the lowest pending index");
      end
   end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
   import vpic_pkg::*;
#(
   parameter int             N_EXT    = 2,
   parameter int             N_INT    = 4,
   parameter logic [2*N_EXT-1:0] EXT_EDGE = {EDGE_BOTH, EDGE_FALL},
   parameter int             STAGES   = 2,
   parameter int             VW       = 8,
   parameter int             VEC_BASE = 4,
   parameter int             VEC_STEP = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_EXT-1:0]       ext_pin_i,
   input  logic [N_INT-1:0]       evt_i,
   input  logic                   cfg_we_i,
   input  logic [N_EXT+N_INT-1:0] cfg_en_i,
   input  logic                   cfg_master_i,
   input  logic [N_EXT+N_INT-1:0] flag_clr_i,
   input  logic                   reti_i,
   input  logic                   stack_full_i,
   output logic                   call_o,
   output logic [VW-1:0]          vec_o,
   output logic                   wake_o,
   output logic [N_EXT+N_INT-1:0] flag_o,
   output logic [N_EXT+N_INT-1:0] en_o,
   output logic                   master_o
);
   localparam int NSRC = N_EXT + N_INT;

   if (VEC_BASE + VEC_STEP * (NSRC - 1) >= (1 << VW)) begin : g_bad_vec
      $error("vpic_top: vector range does not fit in VW bits");
   end
   if (N_EXT < 1 || N_INT < 1) begin : g_bad_cnt
      $error("vpic_top: need at least one source of each kind");
   end

   logic [NSRC-1:0]  flag_q, en_q, pend, sel, set_v, svc_clr;
   logic             master_q, any_pend;
   logic [N_EXT-1:0] ext_hit;

   for (genvar k = 0; k < N_EXT; k++) begin : g_ext
      vpic_edge_det #(
         .MODE   (EXT_EDGE[2*k +: 2]),
         .STAGES (STAGES),
         .IDLE   (1'b1)
      ) u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_i (ext_pin_i[k]),
         .hit_o (ext_hit[k])
      );
   end

   assign set_v = {evt_i, ext_hit};
   assign pend  = flag_q & en_q;

   vpic_prio #(
      .NSRC     (NSRC),
      .VW       (VW),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP)
   ) u_prio (
      .pend_i (pend),
      .any_o  (any_pend),
      .sel_o  (sel),
      .vec_o  (vec_o)
   );

   assign call_o  = master_q & ~stack_full_i & any_pend;
   assign svc_clr = call_o ? sel : '0;
   assign wake_o  = any_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q   <= '0;
         en_q     <= '0;
         master_q <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~flag_clr_i & ~svc_clr) | set_v;
         if (cfg_we_i) begin
            en_q     <= cfg_en_i;
            master_q <= cfg_master_i;
         end else if (call_o) begin
            master_q <= 1'b0;
         end else if (reti_i) begin
            master_q <= 1'b1;
         end
      end
   end

   assign flag_o   = flag_q;
   assign en_o     = en_q;
   assign master_o = master_q;

   // R1: nothing requested while reset is held
   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!call_o && !wake_o)
            else $error("request visible during reset");
      end
   end

   // R2: a call needs some enabled pending flag
   assert_call_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
      call_o |-> ((flag_o & en_o) != '0));

   // R4: entry clears the master enable unless a write overrides it
   assert_entry_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (call_o && !cfg_we_i) |=> !master_q);

   // R4: entry clears the serviced flag unless a new event re-sets it
   assert_entry_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (call_o && ((set_v & sel) == '0)) |=> ((flag_q & $past(sel)) == '0));

   // R5: no call with the master enable off
   assert_masked_no_call_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !master_q |-> !call_o);

   // R6: full stack holds calls off
   assert_stack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stack_full_i |-> !call_o);

   // R7: return strobe re-arms the master enable
   assert_reti_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !cfg_we_i && !call_o) |=> master_q);

   // R8: a flag only falls by a software clear or by being serviced
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_q) |=> (($past(flag_q) & ~flag_q & ~$past(flag_clr_i) & ~$past(svc_clr)) == '0));

   // R10: a detected pin edge always lands in its flag
   assert_ext_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|ext_hit) |=> ((flag_q[N_EXT-1:0] & $past(ext_hit)) == $past(ext_hit)));

   // R11: a write loads enables and master enable
   assert_cfg_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we_i |=> ((en_q == $past(cfg_en_i)) && (master_q == $past(cfg_master_i))));
endmodule

// File: tb/vpic_top_tb.sv
module vpic_top_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] ext_pin_i;
   logic [3:0] evt_i;
   logic       cfg_we_i;
   logic [5:0] cfg_en_i;
   logic       cfg_master_i;
   logic [5:0] flag_clr_i;
   logic       reti_i;
   logic       stack_full_i;
   logic       call_o;
   logic [7:0] vec_o;
   logic       wake_o;
   logic [5:0] flag_o;
   logic [5:0] en_o;
   logic       master_o;

   always #4 clk = ~clk;   // 125 MHz

   vpic_top u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_pin_i    (ext_pin_i),
      .evt_i        (evt_i),
      .cfg_we_i     (cfg_we_i),
      .cfg_en_i     (cfg_en_i),
      .cfg_master_i (cfg_master_i),
      .flag_clr_i   (flag_clr_i),
      .reti_i       (reti_i),
      .stack_full_i (stack_full_i),
      .call_o       (call_o),
      .vec_o        (vec_o),
      .wake_o       (wake_o),
      .flag_o       (flag_o),
      .en_o         (en_o),
      .master_o     (master_o)
   );

   int         checks = 0;
   int         bad    = 0;
   bit         done   = 0;
   logic [7:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", checks, bad);
   endtask

   // monitor: every call must match the next expected vector
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n === 1'b1 && call_o === 1'b1) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected call vector", int'(vec_o), 0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(vec_o == e, "R3", "call vector", int'(vec_o), int'(e));
            end
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [5:0] en, input logic m);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_en_i = en; cfg_master_i = m;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   task automatic reti_p();
      @(negedge clk);
      reti_i = 1'b1;
      @(negedge clk);
      reti_i = 1'b0;
   endtask

   task automatic evt(input logic [3:0] m);
      @(negedge clk);
      evt_i = m;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic clr(input logic [5:0] m);
      @(negedge clk);
      flag_clr_i = m;
      @(negedge clk);
      flag_clr_i = '0;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ext_pin_i = 2'b11; evt_i = '0; cfg_we_i = 1'b0;
      cfg_en_i = '0; cfg_master_i = 1'b0; flag_clr_i = '0; reti_i = 1'b0;
      stack_full_i = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      #2;
      chk(flag_o == 0, "R1", "flags after reset", int'(flag_o), 0);
      chk(en_o == 0 && master_o == 0, "R1", "enables after reset", int'({master_o, en_o}), 0);
      chk(!call_o && !wake_o, "R1", "call/wake after reset", int'({call_o, wake_o}), 0);

      // R5 / R9: events recorded while master enable is off
      cfg(6'h3F, 1'b0);
      evt(4'b1010);
      #2;
      chk(flag_o == 6'b101000, "R5", "flags held pending", int'(flag_o), 'h28);
      chk(!call_o, "R5", "no call with master off", int'(call_o), 0);
      chk(wake_o, "R9", "wake with master off", int'(wake_o), 1);
      cyc(2);
      chk(flag_o == 6'b101000, "R8", "flags sticky", int'(flag_o), 'h28);

      // R6: full stack holds the call off
      @(negedge clk);
      stack_full_i = 1'b1;
      cfg(6'h3F, 1'b1);
      #2;
      chk(!call_o && master_o, "R6", "no call while stack full", int'({call_o, master_o}), 1);
      cyc(2);
      chk(flag_o == 6'b101000, "R6", "flags kept while stack full", int'(flag_o), 'h28);
      exp_q.push_back(8'h10);
      @(negedge clk);
      stack_full_i = 1'b0;
      @(negedge clk);
      #2;
      chk(!master_o, "R4", "master cleared on entry", int'(master_o), 0);
      chk(flag_o == 6'b100000, "R4", "only serviced flag cleared", int'(flag_o), 'h20);
      chk(!call_o, "R4", "no nested call", int'(call_o), 0);

      // R7: return re-arms and the next pending source is taken
      exp_q.push_back(8'h18);
      reti_p();
      @(negedge clk);
      #2;
      chk(exp_q.size() == 0, "R7", "call after return", exp_q.size(), 0);
      chk(flag_o == 0 && !master_o, "R7", "state after second entry", int'({master_o, flag_o}), 0);

      // R3: full internal priority order
      evt(4'b1111);
      exp_q.push_back(8'h0C); exp_q.push_back(8'h10);
      exp_q.push_back(8'h14); exp_q.push_back(8'h18);
      for (int i = 0; i < 4; i++) begin
         reti_p();
         cyc(1);
      end
      #2;
      chk(flag_o == 0 && exp_q.size() == 0, "R3", "all drained in order", int'(flag_o), 0);

      // R10: pin 0 falling only, three-edge latency
      @(negedge clk);
      ext_pin_i[0] = 1'b0;
      cyc(2);
      #2;
      chk(flag_o[0] == 1'b0, "R10", "pin0 flag not yet set after two edges", int'(flag_o[0]), 0);
      cyc(1);
      #2;
      chk(flag_o[0] == 1'b1, "R10", "pin0 flag set on third edge", int'(flag_o[0]), 1);
      clr(6'b000001);
      @(negedge clk);
      ext_pin_i[0] = 1'b1;
      cyc(5);
      #2;
      chk(flag_o[0] == 1'b0, "R10", "pin0 rising edge ignored", int'(flag_o[0]), 0);
      @(negedge clk);
      ext_pin_i[1] = 1'b0;
      cyc(5);
      #2;
      chk(flag_o[1] == 1'b1, "R10", "pin1 falling edge", int'(flag_o[1]), 1);
      clr(6'b000010);
      #2;
      chk(flag_o[1] == 1'b0, "R8", "software clear", int'(flag_o[1]), 0);
      @(negedge clk);
      ext_pin_i[1] = 1'b1;
      cyc(5);
      #2;
      chk(flag_o[1] == 1'b1, "R10", "pin1 rising edge", int'(flag_o[1]), 1);
      clr(6'b000010);

      // R8: event beats clear in the same cycle
      evt(4'b0001);
      @(negedge clk);
      flag_clr_i = 6'b000100; evt_i = 4'b0001;
      @(negedge clk);
      flag_clr_i = '0; evt_i = '0;
      #2;
      chk(flag_o[2] == 1'b1, "R8", "event wins over clear", int'(flag_o[2]), 1);
      clr(6'b000100);
      #2;
      chk(flag_o == 0, "R8", "flag cleared", int'(flag_o), 0);

      // R3 / R9 / R2: disabled high-priority flag beside an enabled one
      cfg(6'b111110, 1'b0);
      @(negedge clk);
      ext_pin_i[0] = 1'b0;
      cyc(5);
      evt(4'b0001);
      exp_q.push_back(8'h0C);
      cfg(6'b111110, 1'b1);
      @(negedge clk);
      #2;
      chk(flag_o == 6'b000001, "R3", "disabled source skipped", int'(flag_o), 1);
      chk(!wake_o, "R9", "disabled flag gives no wake", int'(wake_o), 0);
      cfg(6'b111110, 1'b1);
      #2;
      chk(!call_o && master_o, "R2", "disabled flag gives no call", int'({call_o, master_o}), 1);

      // R11: write beats return in the same cycle
      cfg(6'h3F, 1'b0);
      #2;
      chk(wake_o && !call_o, "R11", "enable loaded, master off", int'({wake_o, call_o}), 2);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_en_i = 6'h3F; cfg_master_i = 1'b0; reti_i = 1'b1;
      @(negedge clk);
      cfg_we_i = 1'b0; reti_i = 1'b0;
      #2;
      chk(!master_o && !call_o, "R11", "write beats return", int'({master_o, call_o}), 0);
      exp_q.push_back(8'h04);
      reti_p();
      @(negedge clk);
      ext_pin_i[0] = 1'b1;
      #2;
      chk(flag_o == 0 && !master_o, "R4", "pin0 serviced", int'({master_o, flag_o}), 0);

      cyc(4);
      chk(exp_q.size() == 0, "R3", "all expected calls seen", exp_q.size(), 0);
      done = 1;
      summary();
      $finish;
   end
endmodule